// File: doc/BRIEF.md
# Hashed Frame-Table Lookup Engine

This block answers one question for the memory system: which physical frame, if any, currently holds a given virtual page of a given process. The table it searches has one entry per physical frame, so the table grows with installed memory and not with the virtual address width. Each entry names the process and virtual page that occupy its frame, and the index of the entry is the frame number.

A request carries a process ID, a virtual page number and a read/write flag. The engine hashes the process ID and the page number into a starting slot, reads that entry through a one-cycle-latency read port, and compares it against the request. On a mismatch it follows the entry's next-index link to another slot, reading one entry per probe, until it finds a match, reaches a chain terminator or has made as many probes as the table has entries. It then returns a single registered response with the frame number, the entry's attribute bits, the outcome and the number of probes it made. Software builds and edits the table and its chains. This block only reads them.

Top module: `ipt_lookup`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `req_ready` is 1 and `resp_valid` and `mem_rd_en` are 0. A walk cut short by reset produces no response.
- R2: The first entry read for a request is at slot `(vpn ^ (pid << PID_SHIFT)) mod FRAMES`, where FRAMES is a power of two. The read is issued in the cycle after the request is accepted.
- R3: Each table entry is packed from MSB to LSB as valid (1 bit), pid (PID_W), vpn (VPN_W), attr (ATTR_W), next (log2(FRAMES)+1 bits). An entry matches only when valid is 1 and both pid and vpn equal the request. On a match the response carries the slot index as `resp_frame` and the entry's attr as `resp_attr`.
- R4: On a mismatch, the next read goes to the slot named by the low log2(FRAMES) bits of next. `resp_probes` reports how many entries were read for the request, counting the first one.
- R5: An entry whose next field has its MSB set ends the chain. A mismatch there gives a miss with `resp_hit`=0, `resp_denied`=0, `resp_frame`=0, `resp_attr`=0.
- R6: An entry with valid=0 never matches, even when its pid and vpn equal the request. The walk continues along its next link.
- R7: When FRAMES probes have been made without a match, the walk stops and reports a miss with `resp_probes`=FRAMES. This covers circular chains.
- R8: Attr bit WR_BIT marks a page writable. A write request that matches an entry with that bit clear returns `resp_denied`=1 and `resp_hit`=0, with the frame and attr still reported. A read request to the same entry, or any request to a writable entry, returns `resp_hit`=1.
- R9: During a walk `req_ready` is 0. A request presented then is neither accepted nor allowed to alter the ongoing walk's result.
- R10: Each accepted request yields exactly one response, and `resp_valid` is high for a single cycle.
- R11: For a request answered after p probes, `resp_valid` rises 2*p clock edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle; request accepted when both high |
| req_pid | input | PID_W | Requesting process ID |
| req_vpn | input | VPN_W | Virtual page number to find |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | log2(FRAMES) | Slot to read |
| mem_rd_data | input | 1+PID_W+VPN_W+ATTR_W+log2(FRAMES)+1 | Entry, valid one cycle after the strobe |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Match found and access permitted |
| resp_denied | output | 1 | Match found but write not allowed |
| resp_frame | output | log2(FRAMES) | Matching frame number |
| resp_attr | output | ATTR_W | Attribute bits of the matching entry |
| resp_probes | output | log2(FRAMES+1) | Entries read for this request |

## Verification
The bench builds a table with a four-deep chain that passes through an invalid entry holding the same key as a live entry further down. A design that ignored the valid bit would stop one probe early with the wrong frame. The table also has a self-linked slot, which a design without the probe limit would walk forever, and a link to the highest slot, which a design that read the end marker from the wrong bit would treat as a terminator. Keys share a page number but differ in process ID, so a hash or compare that dropped the ID would return a false hit. Requests held on the port during a walk, and a reset partway through a walk, expose a design that accepts a second request or leaves a stale response pending. The latency and first-slot checks catch an off-by-one in the read pipeline.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EVAL = 2'd2
  } walk_st_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int PID_W     = 6,
  parameter int VPN_W     = 20,
  parameter int IDX_W     = 4,
  parameter int PID_SHIFT = 2
) (
  input  logic [PID_W-1:0] pid,
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] slot
);
  localparam int PW   = PID_W + PID_SHIFT;
  localparam int WIDE = (VPN_W > PW) ? VPN_W : PW;

  logic [WIDE-1:0] v_ext;
  logic [WIDE-1:0] p_ext;
  logic [WIDE-1:0] mix;

  assign v_ext = WIDE'(vpn);
  assign p_ext = WIDE'(pid) << PID_SHIFT;
  assign mix   = v_ext ^ p_ext;
  // table size is a power of two, so the modulo keeps the low bits
  assign slot  = mix[IDX_W-1:0];

  generate
    if (WIDE > IDX_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^mix[WIDE-1:IDX_W];
    end
  endgenerate
endmodule

// File: rtl/ipt_match.sv
module ipt_match #(
  parameter int PID_W  = 6,
  parameter int VPN_W  = 20,
  parameter int ATTR_W = 3,
  parameter int NXT_W  = 5,
  parameter int WR_BIT = 0,
  parameter int ENT_W  = 1 + PID_W + VPN_W + ATTR_W + NXT_W
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [PID_W-1:0] key_pid,
  input  logic [VPN_W-1:0] key_vpn,
  input  logic             key_wr,
  output logic             key_hit,
  output logic             perm_ok,
  output logic             chain_end
);
  logic              e_valid;
  logic [PID_W-1:0]  e_pid;
  logic [VPN_W-1:0]  e_vpn;
  logic [ATTR_W-1:0] e_attr;
  logic              unused_link;

  assign e_valid = entry[ENT_W-1];
  assign e_pid   = entry[ENT_W-2 -: PID_W];
  assign e_vpn   = entry[NXT_W+ATTR_W +: VPN_W];
  assign e_attr  = entry[NXT_W +: ATTR_W];

  assign key_hit   = e_valid && (e_pid == key_pid) && (e_vpn == key_vpn);
  assign perm_ok   = !key_wr || e_attr[WR_BIT];
  assign chain_end = entry[NXT_W-1];
  assign unused_link = ^entry[NXT_W-2:0];
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup
  import ipt_pkg::*;
#(
  parameter int FRAMES    = 16,
  parameter int PID_W     = 6,
  parameter int VPN_W     = 20,
  parameter int ATTR_W    = 3,
  parameter int PID_SHIFT = 2,
  parameter int WR_BIT    = 0,
  localparam int IDX_W    = $clog2(FRAMES),
  localparam int NXT_W    = IDX_W + 1,
  localparam int ENT_W    = 1 + PID_W + VPN_W + ATTR_W + NXT_W,
  localparam int CNT_W    = $clog2(FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic              req_write,
  output logic              mem_rd_en,
  output logic [IDX_W-1:0]  mem_rd_addr,
  input  logic [ENT_W-1:0]  mem_rd_data,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_denied,
  output logic [IDX_W-1:0]  resp_frame,
  output logic [ATTR_W-1:0] resp_attr,
  output logic [CNT_W-1:0]  resp_probes
);
  walk_st_e          state;
  logic [PID_W-1:0]  key_pid;
  logic [VPN_W-1:0]  key_vpn;
  logic              key_wr;
  logic [CNT_W-1:0]  probes;
  logic [IDX_W-1:0]  hash_idx;
  logic              key_hit;
  logic              perm_ok;
  logic              chain_end;
  logic              accept;
  logic              at_limit;
  logic [IDX_W-1:0]  link_idx;
  logic [ATTR_W-1:0] ent_attr;

  ipt_hash #(
    .PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(IDX_W), .PID_SHIFT(PID_SHIFT)
  ) u_hash (
    .pid(req_pid), .vpn(req_vpn), .slot(hash_idx)
  );

  ipt_match #(
    .PID_W(PID_W), .VPN_W(VPN_W), .ATTR_W(ATTR_W), .NXT_W(NXT_W),
    .WR_BIT(WR_BIT), .ENT_W(ENT_W)
  ) u_match (
    .entry(mem_rd_data), .key_pid(key_pid), .key_vpn(key_vpn),
    .key_wr(key_wr), .key_hit(key_hit), .perm_ok(perm_ok),
    .chain_end(chain_end)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign at_limit  = (probes == CNT_W'(FRAMES));
  assign link_idx  = mem_rd_data[IDX_W-1:0];
  assign ent_attr  = mem_rd_data[NXT_W +: ATTR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      key_pid     <= '0;
      key_vpn     <= '0;
      key_wr      <= 1'b0;
      probes      <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_denied <= 1'b0;
      resp_frame  <= '0;
      resp_attr   <= '0;
      resp_probes <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_rd_en  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            key_pid     <= req_pid;
            key_vpn     <= req_vpn;
            key_wr      <= req_write;
            probes      <= CNT_W'(1);
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= hash_idx;
            state       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (key_hit) begin
            resp_valid  <= 1'b1;
            resp_hit    <= perm_ok;
            resp_denied <= !perm_ok;
            resp_frame  <= mem_rd_addr;
            resp_attr   <= ent_attr;
            resp_probes <= probes;
            state       <= ST_IDLE;
          end else if (chain_end || at_limit) begin
            resp_valid  <= 1'b1;
            resp_hit    <= 1'b0;
            resp_denied <= 1'b0;
            resp_frame  <= '0;
            resp_attr   <= '0;
            resp_probes <= probes;
            state       <= ST_IDLE;
          end else begin
            probes      <= probes + CNT_W'(1);
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= link_idx;
            state       <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  first_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_rd_en && mem_rd_addr == $past(hash_idx)));

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);

  // R4
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R7
  probe_bound_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_probes != '0 && resp_probes <= CNT_W'(FRAMES)));

  // R8
  hit_deny_excl_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !(resp_hit && resp_denied));
endmodule

// File: tb/sim_ipt_lookup.sv
`timescale 1ns/1ps
module sim_ipt_lookup;
  localparam int FRAMES = 16;
  localparam int PID_W  = 6;
  localparam int VPN_W  = 20;
  localparam int ATTR_W = 3;
  localparam int IDX_W  = 4;
  localparam int NXT_W  = 5;
  localparam int ENT_W  = 1 + PID_W + VPN_W + ATTR_W + NXT_W;
  localparam int CNT_W  = 5;
  localparam logic [NXT_W-1:0] LEND = 5'b10000;

  typedef struct packed {
    logic [3:0]  tag;
    logic [5:0]  pid;
    logic [19:0] vpn;
    logic        wr;
    logic        hit;
    logic        den;
    logic [3:0]  frame;
    logic [4:0]  probes;
    logic [2:0]  attr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 6'd1, 20'h00001, 1'b0, 1'b1, 1'b0, 4'd5,  5'd1,  3'b001}, // R3 head hit
    '{4'd4, 6'd2, 20'h0000D, 1'b0, 1'b1, 1'b0, 4'd9,  5'd2,  3'b100}, // R4 second link
    '{4'd8, 6'd2, 20'h0000D, 1'b1, 1'b0, 1'b1, 4'd9,  5'd2,  3'b100}, // R8 write denied
    '{4'd6, 6'd3, 20'h00049, 1'b0, 1'b1, 1'b0, 4'd2,  5'd4,  3'b011}, // R6 skip invalid twin
    '{4'd8, 6'd3, 20'h00049, 1'b1, 1'b1, 1'b0, 4'd2,  5'd4,  3'b011}, // R8 write allowed
    '{4'd5, 6'd4, 20'h00015, 1'b0, 1'b0, 1'b0, 4'd0,  5'd4,  3'b000}, // R5 chain end miss
    '{4'd3, 6'd5, 20'h00001, 1'b0, 1'b0, 1'b0, 4'd0,  5'd4,  3'b000}, // R3 pid differs
    '{4'd3, 6'd0, 20'h00030, 1'b1, 1'b1, 1'b0, 4'd0,  5'd1,  3'b101}, // R3 slot zero
    '{4'd5, 6'd0, 20'h00007, 1'b0, 1'b0, 1'b0, 4'd0,  5'd1,  3'b000}, // R5 single mismatch
    '{4'd7, 6'd0, 20'h00013, 1'b0, 1'b0, 1'b0, 4'd0,  5'd16, 3'b000}, // R7 self loop
    '{4'd4, 6'd1, 20'h00012, 1'b0, 1'b1, 1'b0, 4'd15, 5'd2,  3'b111}, // R4 link to top slot
    '{4'd8, 6'd1, 20'h00002, 1'b1, 1'b1, 1'b0, 4'd6,  5'd1,  3'b001}, // R8 writable head
    '{4'd5, 6'd0, 20'h0000A, 1'b0, 1'b0, 1'b0, 4'd0,  5'd1,  3'b000}  // R5 empty slot
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [PID_W-1:0] req_pid = '0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic req_write = 1'b0;
  logic mem_rd_en;
  logic [IDX_W-1:0] mem_rd_addr;
  logic [ENT_W-1:0] mem_rd_data;
  logic resp_valid, resp_hit, resp_denied;
  logic [IDX_W-1:0] resp_frame;
  logic [ATTR_W-1:0] resp_attr;
  logic [CNT_W-1:0] resp_probes;

  logic [ENT_W-1:0] table_mem [FRAMES];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= table_mem[mem_rd_addr];
  end

  ipt_lookup u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vpn(req_vpn), .req_write(req_write),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_denied(resp_denied),
    .resp_frame(resp_frame), .resp_attr(resp_attr), .resp_probes(resp_probes)
  );

  function automatic logic [ENT_W-1:0] mk(logic v, logic [5:0] p, logic [19:0] vp,
                                          logic [2:0] a, logic [4:0] n);
    return {v, p, vp, a, n};
  endfunction

  function automatic int exp_slot(int p, int v);
    return (v ^ (p << 2)) & (FRAMES - 1);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // result of the last request
  int r_lat, r_first, r_first_en, r_after;
  logic r_hit, r_den;
  int r_frame, r_probes, r_attr;

  task automatic run_req(logic [5:0] p, logic [19:0] v, logic w);
    @(negedge clk);
    req_pid = p; req_vpn = v; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_first = int'(mem_rd_addr);
    r_first_en = int'(mem_rd_en);
    r_lat = 1;
    while (!resp_valid && r_lat < 200) begin
      @(negedge clk);
      r_lat++;
    end
    r_hit = resp_hit; r_den = resp_denied;
    r_frame = int'(resp_frame); r_probes = int'(resp_probes); r_attr = int'(resp_attr);
    @(negedge clk);
    r_after = int'(resp_valid);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    summary();
  end

  initial begin
    for (int i = 0; i < FRAMES; i++) table_mem[i] = mk(1'b0, 6'd0, 20'h0, 3'b000, LEND);
    table_mem[5]  = mk(1'b1, 6'd1, 20'h00001, 3'b001, 5'd9);
    table_mem[9]  = mk(1'b1, 6'd2, 20'h0000D, 3'b100, 5'd12);
    table_mem[12] = mk(1'b0, 6'd3, 20'h00049, 3'b011, 5'd2);
    table_mem[2]  = mk(1'b1, 6'd3, 20'h00049, 3'b011, LEND);
    table_mem[0]  = mk(1'b1, 6'd0, 20'h00030, 3'b101, LEND);
    table_mem[7]  = mk(1'b1, 6'd0, 20'h00017, 3'b000, LEND);
    table_mem[3]  = mk(1'b1, 6'd0, 20'h00023, 3'b000, 5'd3);
    table_mem[6]  = mk(1'b1, 6'd1, 20'h00002, 3'b001, 5'd15);
    table_mem[15] = mk(1'b1, 6'd1, 20'h00012, 3'b111, LEND);

    repeat (3) @(negedge clk);
    // R1 state during reset
    chk("R1", "ready in reset", int'(req_ready), 1);
    chk("R1", "resp_valid in reset", int'(resp_valid), 0);
    chk("R1", "rd_en in reset", int'(mem_rd_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", int'(req_ready), 1);

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[i].tag, i);
      run_req(VECS[i].pid, VECS[i].vpn, VECS[i].wr);
      chk(tg, "hit", int'(r_hit), int'(VECS[i].hit));
      chk(tg, "denied", int'(r_den), int'(VECS[i].den));
      chk(tg, "frame", r_frame, int'(VECS[i].frame));
      chk(tg, "probes", r_probes, int'(VECS[i].probes));
      chk(tg, "attr", r_attr, int'(VECS[i].attr));
      chk("R2", "first read strobe", r_first_en, 1);
      chk("R2", "first slot", r_first, exp_slot(int'(VECS[i].pid), int'(VECS[i].vpn)));
      chk("R11", "latency", r_lat, 2 * int'(VECS[i].probes) + 1);
      chk("R10", "single-cycle strobe", r_after, 0);
    end

    // R9: a second request held during a walk is not taken
    @(negedge clk);
    req_pid = 6'd1; req_vpn = 20'h00001; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_pid = 6'd2; req_vpn = 20'h0000D;
    chk("R9", "ready while busy", int'(req_ready), 0);
    r_lat = 1;
    while (!resp_valid && r_lat < 200) begin
      @(negedge clk);
      r_lat++;
    end
    req_valid = 1'b0;
    chk("R9", "busy result frame", int'(resp_frame), 5);
    chk("R9", "busy result probes", int'(resp_probes), 1);
    begin
      int extra = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (resp_valid || mem_rd_en) extra++;
      end
      chk("R10", "no extra response or read", extra, 0);
    end

    // R1: reset in the middle of a long walk
    @(negedge clk);
    req_pid = 6'd0; req_vpn = 20'h00013; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "ready after mid-walk reset", int'(req_ready), 1);
    chk("R1", "rd_en after mid-walk reset", int'(mem_rd_en), 0);
    rst = 1'b0;
    begin
      int extra = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (resp_valid) extra++;
      end
      chk("R1", "no response from aborted walk", extra, 0);
    end
    run_req(6'd3, 20'h00049, 1'b0);
    chk("R6", "recovery hit past invalid twin", int'(r_hit), 1);
    chk("R6", "recovery frame", r_frame, 2);

    summary();
  end
endmodule